// File: doc/BRIEF.md
# Fused multiply-add mantissa datapath

This block is the arithmetic heart of a single-precision fused multiply-add and multiply-subtract unit. It works only on finite operands whose product is nonzero. Class decoding (NaN, infinity and zero products) is done upstream, and the rounder downstream turns the result into a packed value. Each operand arrives unpacked: a sign, an unbiased two's-complement exponent and a 24-bit mantissa with the hidden bit set. A flag marks an addend of zero. A mode bit negates the product. A second bit tells the block that the active rounding direction is toward minus infinity.

The block forms the exact 48-bit product with no intermediate rounding. It places the product and the addend in a 64-bit working field with the leading one at bit 62, and shifts the operand with the smaller exponent right. Every bit lost in that shift is folded into bit 0. The block then adds or subtracts magnitudes, normalizes with a leading-zero count and one barrel shift, and hands over a sign, an exponent and a 27-bit mantissa: 24 significant bits plus three guard bits for rounding.

Operands enter through a valid/ready handshake, pass through two register stages, and leave through a valid/ready handshake with one result per accepted operand set, in order.

Top module: `fma_mant_core`

## Requirements
- R1: The product sign is `x_sign ^ y_sign ^ sub_mode`. The product exponent is `x_exp + y_exp`.
- R2: The product is exact. When the mantissa product is 2 or more, the exponent is raised by one so that the leading one stays at bit 62. All three input mantissas carry bit 23 set.
- R3: With `z_is_zero` high, the result is the product alone: its sign, its exponent and its 27-bit mantissa. For 1.0 × 1.0 this gives exponent 0 and mantissa 27'h4000000.
- R4: With a nonzero addend, the operand with the smaller exponent is shifted right by the exponent difference with sticky collection, and the result starts from the larger exponent. This holds for any difference, including differences of 64 or more.
- R5: When the product sign and `z_sign` agree, the magnitudes are added. A carry into bit 63 shifts the sum right by one with sticky collection and raises the exponent by one.
- R6: When the signs differ, the smaller magnitude is taken from the larger, and the result takes the sign of the larger operand.
- R7: An exact cancellation yields `out_mant` = 0 and `out_exp` = 0. `out_sign` then equals `round_down`.
- R8: Every nonzero result has `out_mant[26]` set. After a subtraction, the exponent is lowered by the number of positions the difference was shifted left.
- R9: The 27-bit mantissa is bits 62..36 of the working field. Bits 35..0 are ORed into mantissa bit 0.
- R10: While `out_valid` is high and `out_ready` is low, `out_sign`, `out_exp` and `out_mant` hold. Results leave in acceptance order, one per accepted input, none lost or repeated.
- R11: An input accepted into an empty block appears at the output two clock cycles later. `in_ready` is low only while the output is stalled.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken |
| x_sign | input | 1 | Sign of multiplicand |
| x_exp | input | EXP_W | Unbiased exponent of multiplicand, signed |
| x_mant | input | MANT_W | Mantissa of multiplicand, hidden bit set |
| y_sign | input | 1 | Sign of multiplier |
| y_exp | input | EXP_W | Unbiased exponent of multiplier, signed |
| y_mant | input | MANT_W | Mantissa of multiplier, hidden bit set |
| z_sign | input | 1 | Sign of addend |
| z_exp | input | EXP_W | Unbiased exponent of addend, signed |
| z_mant | input | MANT_W | Mantissa of addend, hidden bit set |
| z_is_zero | input | 1 | Addend is zero; only the product is passed on |
| sub_mode | input | 1 | Negate the product (multiply-subtract) |
| round_down | input | 1 | Rounding toward minus infinity is active |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W+2 | Result exponent, signed |
| out_mant | output | OUT_W | Normalized mantissa with three guard bits |

## Verification
The assertions take for granted that every offered operand set carries the hidden bit in all three mantissas. The normalization property on nonzero results depends on it, so one assertion checks it at the input. Exponents are assumed to lie in the single-precision range from -149 to 127, so that sums and normalization shifts fit the internal exponent width. The stimulus draws every mantissa with bit 23 forced on and clamps all exponents to that range. It then adds directed deep cancellations, extreme exponent gaps and exact cancellations under both rounding-direction values.

// File: rtl/fma_core_pkg.sv
// Shared constants, the path selector type and the sticky right shift
// used by both datapath stages of the fused multiply-add core.
package fma_core_pkg;

    localparam int unsigned WORD_W  = 64;
    localparam int unsigned SHAMT_W = 16;

    // Which arithmetic the second stage performs
    typedef enum logic [1:0] {
        PATH_PROD = 2'd0,
        PATH_ADD  = 2'd1,
        PATH_SUB  = 2'd2
    } fma_path_e;

    // Logical right shift; any one shifted out sets bit 0 of the result.
    // Shifts of WORD_W or more leave only the sticky bit.
    function automatic logic [WORD_W-1:0] sticky_shr(
        input logic [WORD_W-1:0]  v,
        input logic [SHAMT_W-1:0] amt
    );
        logic [WORD_W-1:0] kept;
        logic [WORD_W-1:0] lost_mask;
        kept      = '0;
        lost_mask = '0;
        if (amt >= SHAMT_W'(WORD_W)) begin
            kept = {{(WORD_W-1){1'b0}}, |v};
        end else begin
            lost_mask = ~({WORD_W{1'b1}} << amt);
            kept      = (v >> amt) | {{(WORD_W-1){1'b0}}, |(v & lost_mask)};
        end
        return kept;
    endfunction

endpackage

// File: rtl/fma_lzc.sv
// Leading-zero counter. Counts zeros above the highest set bit of vec.
// An all-zero vector returns W. Purely combinational.
module fma_lzc #(
    parameter int unsigned W  = 63,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    // Scan upward; the highest set bit is the last to overwrite the count
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/fma_prod_align.sv
// First stage: exact product, product normalization to bit WORD_W-2,
// addend placement and sticky alignment to the larger exponent.
// Assumes hidden bits are set on all mantissas. The result is combinational.
module fma_prod_align
    import fma_core_pkg::*;
#(
    parameter int unsigned MANT_W = 24,
    parameter int unsigned EXP_W  = 10,
    parameter int unsigned IW     = EXP_W + 2
) (
    input  logic                     x_sign,
    input  logic signed [EXP_W-1:0]  x_exp,
    input  logic [MANT_W-1:0]        x_mant,
    input  logic                     y_sign,
    input  logic signed [EXP_W-1:0]  y_exp,
    input  logic [MANT_W-1:0]        y_mant,
    input  logic                     z_sign,
    input  logic signed [EXP_W-1:0]  z_exp,
    input  logic [MANT_W-1:0]        z_mant,
    input  logic                     z_is_zero,
    input  logic                     sub_mode,
    output logic [WORD_W-1:0]        p_al,
    output logic [WORD_W-1:0]        z_al,
    output logic signed [IW-1:0]     e_al,
    output logic                     p_sign,
    output fma_path_e                path
);

    localparam int unsigned LEAD   = WORD_W - 2;
    localparam int unsigned PROD_W = 2 * MANT_W;
    localparam int unsigned SH_HI  = LEAD - PROD_W + 1;
    localparam int unsigned SH_LO  = SH_HI + 1;
    localparam int unsigned Z_SH   = LEAD - (MANT_W - 1);

    logic [PROD_W-1:0]     prod;
    logic [WORD_W-1:0]     prod_w;
    logic                  p_top;
    logic [WORD_W-1:0]     p_norm;
    logic [WORD_W-1:0]     z_norm;
    logic signed [IW-1:0]  p_exp;
    logic signed [IW-1:0]  z_exp_w;
    logic signed [IW-1:0]  exp_gap;

    // Exact product, leading one moved to bit LEAD
    always_comb begin
        prod    = PROD_W'(x_mant) * PROD_W'(y_mant);
        prod_w  = WORD_W'(prod);
        p_top   = prod[PROD_W-1];
        p_norm  = p_top ? (prod_w << SH_HI) : (prod_w << SH_LO);
        p_exp   = IW'(x_exp) + IW'(y_exp) + IW'({1'b0, p_top});
        z_norm  = WORD_W'(z_mant) << Z_SH;
        z_exp_w = IW'(z_exp);
        exp_gap = p_exp - z_exp_w;
    end

    // Pick the path and shift the smaller-exponent operand with sticky
    always_comb begin
        p_sign = x_sign ^ y_sign ^ sub_mode;
        p_al   = p_norm;
        z_al   = z_norm;
        e_al   = p_exp;
        if (z_is_zero) begin
            path = PATH_PROD;
        end else begin
            path = (p_sign == z_sign) ? PATH_ADD : PATH_SUB;
            if (exp_gap < 0) begin
                p_al = sticky_shr(p_norm, SHAMT_W'(-exp_gap));
                e_al = z_exp_w;
            end else if (exp_gap > 0) begin
                z_al = sticky_shr(z_norm, SHAMT_W'(exp_gap));
            end
        end
    end

endmodule

// File: rtl/fma_add_norm.sv
// Second stage: magnitude add or subtract, carry handling, normalization
// by leading-zero count and one barrel shift, then sticky reduction to the
// guard-extended output mantissa. Inputs are aligned to a common exponent,
// and each nonzero input has its leading one at or below bit WORD_W-2.
module fma_add_norm
    import fma_core_pkg::*;
#(
    parameter int unsigned IW    = 12,
    parameter int unsigned OUT_W = 27
) (
    input  logic [WORD_W-1:0]    p_in,
    input  logic [WORD_W-1:0]    z_in,
    input  logic signed [IW-1:0] e_in,
    input  logic                 p_sign,
    input  logic                 z_sign,
    input  fma_path_e            path,
    input  logic                 round_down,
    output logic                 r_sign,
    output logic signed [IW-1:0] r_exp,
    output logic [OUT_W-1:0]     r_mant
);

    localparam int unsigned LEAD   = WORD_W - 2;
    localparam int unsigned OUT_SH = LEAD - (OUT_W - 1);
    localparam int unsigned DIFF_W = WORD_W - 1;
    localparam int unsigned CW     = $clog2(DIFF_W + 1);

    logic [WORD_W-1:0] sum_w;
    logic              carry;
    logic              z_ge;
    logic              cancel;
    logic [DIFF_W-1:0] mag_diff;
    logic [CW-1:0]     lead_zeros;
    logic [WORD_W-1:0] norm_w;
    logic [WORD_W-1:0] work;

    // Both sum and difference are formed; the path picks one
    always_comb begin
        sum_w    = p_in + z_in;
        carry    = sum_w[WORD_W-1];
        z_ge     = (z_in >= p_in);
        cancel   = (z_in == p_in);
        mag_diff = DIFF_W'(z_ge ? (z_in - p_in) : (p_in - z_in));
    end

    fma_lzc #(
        .W (DIFF_W),
        .CW(CW)
    ) u_lzc (
        .vec  (mag_diff),
        .count(lead_zeros)
    );

    // Single barrel shift brings the difference back to bit LEAD
    always_comb begin
        norm_w = WORD_W'(mag_diff) << lead_zeros;
    end

    // Result selection and final sticky reduction to OUT_W bits
    always_comb begin
        work   = p_in;
        r_exp  = e_in;
        r_sign = p_sign;
        unique case (path)
            PATH_ADD: begin
                work  = carry ? sticky_shr(sum_w, SHAMT_W'(1)) : sum_w;
                r_exp = e_in + IW'({1'b0, carry});
            end
            PATH_SUB: begin
                if (cancel) begin
                    work   = '0;
                    r_exp  = '0;
                    r_sign = round_down;
                end else begin
                    work   = norm_w;
                    r_exp  = e_in - IW'(lead_zeros);
                    r_sign = z_ge ? z_sign : p_sign;
                end
            end
            default: begin
                work = p_in;
            end
        endcase
        r_mant = OUT_W'(sticky_shr(work, SHAMT_W'(OUT_SH)));
    end

endmodule

// File: rtl/fma_mant_core.sv
// Two-stage pipelined fused multiply-add mantissa datapath with valid/ready
// on both sides. Stage one multiplies and aligns; stage two adds,
// normalizes and holds the result until taken. Assumes finite operands,
// a nonzero product and hidden bits set on all mantissas.
module fma_mant_core
    import fma_core_pkg::*;
#(
    parameter int unsigned MANT_W = 24,
    parameter int unsigned EXP_W  = 10,
    parameter int unsigned OUT_W  = 27
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     x_sign,
    input  logic signed [EXP_W-1:0]  x_exp,
    input  logic [MANT_W-1:0]        x_mant,
    input  logic                     y_sign,
    input  logic signed [EXP_W-1:0]  y_exp,
    input  logic [MANT_W-1:0]        y_mant,
    input  logic                     z_sign,
    input  logic signed [EXP_W-1:0]  z_exp,
    input  logic [MANT_W-1:0]        z_mant,
    input  logic                     z_is_zero,
    input  logic                     sub_mode,
    input  logic                     round_down,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     out_sign,
    output logic signed [EXP_W+1:0]  out_exp,
    output logic [OUT_W-1:0]         out_mant
);

    localparam int unsigned IW = EXP_W + 2;

    logic                  s1_valid;
    logic                  s2_valid;
    logic                  s1_go;
    logic                  load_in;

    logic [WORD_W-1:0]     al_p;
    logic [WORD_W-1:0]     al_z;
    logic signed [IW-1:0]  al_e;
    logic                  al_psign;
    fma_path_e             al_path;

    logic [WORD_W-1:0]     s1_p;
    logic [WORD_W-1:0]     s1_z;
    logic signed [IW-1:0]  s1_e;
    logic                  s1_psign;
    logic                  s1_zsign;
    logic                  s1_rdown;
    fma_path_e             s1_path;

    logic                  an_sign;
    logic signed [IW-1:0]  an_exp;
    logic [OUT_W-1:0]      an_mant;

    // Handshake: stage one moves on when stage two is empty or draining
    always_comb begin
        s1_go    = !s2_valid || out_ready;
        in_ready = !s1_valid || s1_go;
        load_in  = in_valid && in_ready;
    end

    fma_prod_align #(
        .MANT_W(MANT_W),
        .EXP_W (EXP_W),
        .IW    (IW)
    ) u_align (
        .x_sign   (x_sign),
        .x_exp    (x_exp),
        .x_mant   (x_mant),
        .y_sign   (y_sign),
        .y_exp    (y_exp),
        .y_mant   (y_mant),
        .z_sign   (z_sign),
        .z_exp    (z_exp),
        .z_mant   (z_mant),
        .z_is_zero(z_is_zero),
        .sub_mode (sub_mode),
        .p_al     (al_p),
        .z_al     (al_z),
        .e_al     (al_e),
        .p_sign   (al_psign),
        .path     (al_path)
    );

    // Occupancy flags of both stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
        end else begin
            if (in_ready) begin
                s1_valid <= in_valid;
            end
            if (s1_go) begin
                s2_valid <= s1_valid;
            end
        end
    end

    // Stage one data capture on an accepted input
    always_ff @(posedge clk) begin
        if (load_in) begin
            s1_p     <= al_p;
            s1_z     <= al_z;
            s1_e     <= al_e;
            s1_psign <= al_psign;
            s1_zsign <= z_sign;
            s1_rdown <= round_down;
            s1_path  <= al_path;
        end
    end

    fma_add_norm #(
        .IW   (IW),
        .OUT_W(OUT_W)
    ) u_addn (
        .p_in      (s1_p),
        .z_in      (s1_z),
        .e_in      (s1_e),
        .p_sign    (s1_psign),
        .z_sign    (s1_zsign),
        .path      (s1_path),
        .round_down(s1_rdown),
        .r_sign    (an_sign),
        .r_exp     (an_exp),
        .r_mant    (an_mant)
    );

    // Output register: loads only when stage two is free, else holds
    always_ff @(posedge clk) begin
        if (s1_go && s1_valid) begin
            out_sign <= an_sign;
            out_exp  <= an_exp;
            out_mant <= an_mant;
        end
    end

    assign out_valid = s2_valid;

endmodule

// File: rtl/fma_mant_core_chk.sv
// Property checker for the fused multiply-add mantissa core, bound to
// every instance of the top module.
module fma_mant_core_chk #(
    parameter int unsigned MANT_W = 24,
    parameter int unsigned EXP_W  = 10,
    parameter int unsigned OUT_W  = 27
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [MANT_W-1:0]       x_mant,
    input logic [MANT_W-1:0]       y_mant,
    input logic [MANT_W-1:0]       z_mant,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic                    out_sign,
    input logic signed [EXP_W+1:0] out_exp,
    input logic [OUT_W-1:0]        out_mant
);

    // R2: offered operands carry hidden bits
    assert_hidden_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (x_mant[MANT_W-1] && y_mant[MANT_W-1] && z_mant[MANT_W-1]));

    // R8: nonzero results are normalized
    assert_normalized_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_mant != '0)) |-> out_mant[OUT_W-1]);

    // R7: a zero result carries a zero exponent
    assert_zero_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_mant == '0)) |-> (out_exp == '0));

    // R10: stalled result holds
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sign)
                                       && $stable(out_exp) && $stable(out_mant)));

    // R11: input side blocks only behind a stalled output
    assert_ready_only_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

    // R12: leaving reset, nothing is presented
    assert_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

endmodule

bind fma_mant_core fma_mant_core_chk #(
    .MANT_W(MANT_W),
    .EXP_W (EXP_W),
    .OUT_W (OUT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .x_mant   (x_mant),
    .y_mant   (y_mant),
    .z_mant   (z_mant),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_sign (out_sign),
    .out_exp  (out_exp),
    .out_mant (out_mant)
);

// File: tb/fma_mant_core_tb_top.sv
module fma_mant_core_tb_top;

    localparam int unsigned MANT_W = 24;
    localparam int unsigned EXP_W  = 10;
    localparam int unsigned OUT_W  = 27;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic                    x_sign = 1'b0, y_sign = 1'b0, z_sign = 1'b0;
    logic signed [EXP_W-1:0] x_exp = '0, y_exp = '0, z_exp = '0;
    logic [MANT_W-1:0]       x_mant = 24'h800000, y_mant = 24'h800000, z_mant = 24'h800000;
    logic                    z_is_zero = 1'b0, sub_mode = 1'b0, round_down = 1'b0;
    logic                    out_valid;
    logic                    out_ready = 1'b1;
    logic                    out_sign;
    logic signed [EXP_W+1:0] out_exp;
    logic [OUT_W-1:0]        out_mant;

    typedef struct {
        bit          s;
        int          e;
        int unsigned m;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    bit   bp_en  = 1'b0;
    bit   stalled = 1'b0;
    bit   held_s;
    int   held_e;
    int unsigned held_m;

    always #4 clk = ~clk;

    fma_mant_core #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
        .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant),
        .z_sign(z_sign), .z_exp(z_exp), .z_mant(z_mant),
        .z_is_zero(z_is_zero), .sub_mode(sub_mode), .round_down(round_down),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant)
    );

    // Right shift one position at a time, collecting lost ones into bit 0
    function automatic longint unsigned shr_st(longint unsigned v, int n);
        bit st = 1'b0;
        for (int i = 0; i < n; i++) begin
            st = st | v[0];
            v  = v >> 1;
        end
        v[0] = v[0] | st;
        return v;
    endfunction

    // Reference model written from the requirements
    function automatic void model(input bit xs, input int xe, input int unsigned xm,
                                  input bit ys, input int ye, input int unsigned ym,
                                  input bit zs, input int ze, input int unsigned zm,
                                  input bit zz, input bit sub, input bit rd,
                                  output bit rs, output int re, output int unsigned rm);
        longint unsigned a, b, p, z, s, t;
        bit ps;
        int pe, e;
        a = xm; b = ym;
        ps = xs ^ ys ^ sub;
        pe = xe + ye;
        p = (a * b) << 16;
        if (p[63]) begin p = shr_st(p, 1); pe++; end
        if (zz) begin
            t = shr_st(p, 36);
            rs = ps; re = pe; rm = int'(t[26:0]);
            return;
        end
        z = zm;
        z = z << 39;
        e = pe;
        if (pe < ze) begin p = shr_st(p, ze - pe); e = ze; end
        else if (pe > ze) begin z = shr_st(z, pe - ze); end
        if (ps == zs) begin
            s = p + z;
            if (s[63]) begin s = shr_st(s, 1); e++; end
            rs = zs;
        end else if (p == z) begin
            rs = rd; re = 0; rm = 0;
            return;
        end else begin
            if (z > p) begin s = z - p; rs = zs; end
            else begin s = p - z; rs = ps; end
            while (!s[62]) begin s = s << 1; e--; end
        end
        t  = shr_st(s, 36);
        re = e;
        rm = int'(t[26:0]);
    endfunction

    // Driver: present one operand set, wait for acceptance, queue its expectation
    task automatic send(bit xs, int xe, int unsigned xm, bit ys, int ye, int unsigned ym,
                        bit zs, int ze, int unsigned zm, bit zz, bit sub, bit rd, string tag);
        exp_t it;
        model(xs, xe, xm, ys, ye, ym, zs, ze, zm, zz, sub, rd, it.s, it.e, it.m);
        it.tag = tag;
        x_sign = xs; x_exp = EXP_W'(xe); x_mant = MANT_W'(xm);
        y_sign = ys; y_exp = EXP_W'(ye); y_mant = MANT_W'(ym);
        z_sign = zs; z_exp = EXP_W'(ze); z_mant = MANT_W'(zm);
        z_is_zero = zz; sub_mode = sub; round_down = rd;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        q.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: drive out_ready, check held data, pop and compare results
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (stalled) begin
                checks++;
                if (out_valid !== 1'b1 || out_sign !== held_s || int'(out_exp) != held_e
                    || int'(out_mant) != int'(held_m)) begin
                    fails++;
                    $display("FAIL R10 hold: got v=%0b s=%0b e=%0d m=%h expected s=%0b e=%0d m=%h",
                             out_valid, out_sign, out_exp, out_mant, held_s, held_e, held_m);
                end
            end
            out_ready = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
            if (out_valid && out_ready) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R10 extra result: got m=%h expected none", out_mant);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    if (out_sign !== it.s || int'(out_exp) != it.e || int'(out_mant) != int'(it.m)) begin
                        fails++;
                        $display("FAIL %s: got s=%0b e=%0d m=%h expected s=%0b e=%0d m=%h",
                                 it.tag, out_sign, out_exp, out_mant, it.s, it.e, it.m);
                    end
                end
            end
            stalled = out_valid && !out_ready;
            held_s  = out_sign;
            held_e  = int'(out_exp);
            held_m  = int'(out_mant);
        end
    end

    // Watchdog
    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R12: got out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R1 R11: product only, latency from empty
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, 0, "R3_R1");
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 latency: got out_valid=%0b expected 0 one cycle after accept", out_valid);
        end
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || int'(out_exp) != 0 || out_mant !== 27'h4000000) begin
            fails++;
            $display("FAIL R3 R11: got v=%0b e=%0d m=%h expected 1 0 4000000", out_valid, out_exp, out_mant);
        end
        repeat (2) @(negedge clk);

        send(1, 3, 24'hC00000, 0, -5, 24'hC00000, 0, 0, 24'h800000, 1, 0, 0, "R2_R1");
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 24'h800000, 1, 1, 0, "R1_sub");
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 0, "R5_carry");
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 0, -2, 24'hA00000, 0, 0, 0, "R5_nocarry");
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 0, "R7_pos");
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 1, "R7_neg");
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 24'h800000, 0, 1, 1, "R7_submode");
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 0, -100, 24'h800000, 0, 0, 0, "R4_R9_smallz");
        send(0, -60, 24'h800000, 0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 0, "R4_smallp");
        send(0, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, 24'h800001, 0, 0, 0, "R6_R8_deep");
        send(0, 0, 24'hC00000, 0, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 0, "R6_pbig");
        send(0, 127, 24'hFFFFFF, 0, 127, 24'hFFFFFF, 1, -149, 24'h800000, 0, 0, 0, "R4_wide");
        send(1, -149, 24'h800001, 0, -149, 24'h800000, 0, 127, 24'hFFFFFF, 0, 0, 0, "R4_R9_tinyp");

        // Random traffic under backpressure
        bp_en = 1'b1;
        for (int n = 0; n < 500; n++) begin
            bit xs, ys, zs, zz, sub, rd;
            int xe, ye, ze;
            int unsigned xm, ym, zm;
            longint unsigned pr;
            xs = 1'($urandom); ys = 1'($urandom); zs = 1'($urandom);
            sub = 1'($urandom); rd = 1'($urandom);
            zz = ($urandom_range(0, 7) == 0);
            xe = $urandom_range(0, 120) - 60;
            ye = $urandom_range(0, 120) - 60;
            xm = 32'h800000 | ($urandom & 32'h7FFFFF);
            ym = 32'h800000 | ($urandom & 32'h7FFFFF);
            zm = 32'h800000 | ($urandom & 32'h7FFFFF);
            ze = xe + ye + $urandom_range(0, 60) - 30;
            if ($urandom_range(0, 5) == 0) begin
                pr = longint'(xm) * longint'(ym);
                if (pr[47]) begin zm = int'(pr[47:24]); ze = xe + ye + 1; end
                else begin zm = int'(pr[46:23]); ze = xe + ye; end
                zs = ~(xs ^ ys ^ sub);
                zm = zm ^ $urandom_range(0, 3);
                zm = zm | 32'h800000;
            end
            if (ze > 127) ze = 127;
            if (ze < -149) ze = -149;
            send(xs, xe, xm, ys, ye, ym, zs, ze, zm, zz, sub, rd, "R4_R5_R6_R8_R9_rand");
            if ($urandom_range(0, 9) == 0) @(negedge clk);
        end

        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule